// File: doc/BRIEF.md
# Fully Associative Tag Store with Not-Most-Recently-Used Victim Pointer

This block holds the tags of a small fully associative structure. Every entry has a valid flag and a tag, and any tag may sit in any entry. A lookup presents a tag. All entries compare against it in the same cycle, and the block reports a hit together with the binary index of the matching entry. Data storage and the path to memory live elsewhere. This block only answers whether a tag is present, where it is, and which entry should be given up next.

Replacement uses one pointer that always names the next victim. The pointer steps forward by one entry when the entry it names is used, either by a lookup that matches it or by being filled. A use of any other entry leaves the pointer alone. The pointer therefore never names the entry touched most recently, and no per-entry usage history is kept. Each cycle the pointer takes one of four actions: HOLD (nothing touched the named entry), STEP_HIT (a lookup matched it), STEP_FILL (an allocation wrote it), or STEP_BOTH (both in the same cycle). Every action except HOLD moves the pointer one entry forward, and HOLD leaves it in place.

Top module: `fa_nmru_tags`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits, and the victim index is 0.
- R2: `hit` is 1 only when `lkp_valid` is 1 and some valid entry holds a tag equal to `lkp_tag`. When `lkp_valid` is 0 the lookup has no effect on the outputs or on the pointer.
- R3: When several valid entries hold the lookup tag, `hit_idx` gives the lowest-numbered one.
- R4: `alloc_en` writes `alloc_tag` into the entry named by `victim_idx` and marks it valid. A lookup of that tag hits in the following cycle.
- R5: An allocation moves the victim pointer forward by exactly one entry in the next cycle.
- R6: A lookup whose tag matches the valid entry named by the pointer moves the pointer forward by one entry in the next cycle.
- R7: A lookup that misses, or that matches only entries other than the one the pointer names, leaves the pointer unchanged.
- R8: Moving forward from the last entry (ENTRIES-1) takes the pointer to entry 0.
- R9: When a lookup and an allocation occur in the same cycle, the lookup sees the contents from before the write, and the pointer moves at most one entry.
- R10: `hit_idx` is 0 whenever `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | A lookup is presented this cycle |
| lkp_tag | input | TAG_W | Tag to look up |
| alloc_en | input | 1 | Write `alloc_tag` into the victim entry |
| alloc_tag | input | TAG_W | Tag to allocate |
| hit | output | 1 | Lookup matched a valid entry (combinational) |
| hit_idx | output | $clog2(ENTRIES) | Lowest matching entry index, 0 on miss |
| victim_idx | output | $clog2(ENTRIES) | Entry the next allocation will use |

## Verification
The bench builds the block with ENTRIES = 16 and TAG_W = 5, while the defaults are 64 entries with 20-bit tags. With only sixteen entries the pointer wraps many times during the run. With 32 possible tags, random allocations often place a tag that is already stored. Lookups then hit the victim entry and other entries at similar rates. This makes duplicate-tag priority, a lookup that matches the pointed entry in the same cycle it is overwritten, and the step from the last entry to entry 0 occur often, not just once.

// File: rtl/fa_nmru_pkg.sv
package fa_nmru_pkg;

    // Per-cycle action of the victim pointer.
    typedef enum logic [1:0] {
        PTR_HOLD      = 2'b00,
        PTR_STEP_HIT  = 2'b01,
        PTR_STEP_FILL = 2'b10,
        PTR_STEP_BOTH = 2'b11
    } ptr_act_e;

endpackage

// File: rtl/fa_tag_store.sv
module fa_tag_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                wr_tag,
    output logic [ENTRIES-1:0]              valid,
    output logic [ENTRIES-1:0][TAG_W-1:0]   tags
);

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
            end else if (sel) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e] <= wr_tag;
            end
        end
    end

    assign valid = valid_q;
    assign tags  = tag_q;

endmodule

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            req,
    input  logic [TAG_W-1:0]                key,
    input  logic [ENTRIES-1:0]              valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0]   tags,
    output logic [ENTRIES-1:0]              match,
    output logic                            any,
    output logic [IDX_W-1:0]                first
);

    // One comparator per entry, all in parallel.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = req && valid[e] && (tags[e] == key);
    end

    assign any = |match;

    // Lowest-index priority encoder; yields 0 when nothing matches.
    always_comb begin
        first = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                first = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/fa_nmru_ptr.sv
module fa_nmru_ptr
    import fa_nmru_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_hit,
    input  logic               touch_fill,
    output logic [IDX_W-1:0]   ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_d;
    logic [IDX_W-1:0] ptr_inc;
    ptr_act_e         act;

    assign act     = ptr_act_e'({touch_fill, touch_hit});
    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // Next-state selection: any touch of the named entry is a single step.
    always_comb begin
        unique case (act)
            PTR_HOLD:      ptr_d = ptr_q;
            PTR_STEP_HIT:  ptr_d = ptr_inc;
            PTR_STEP_FILL: ptr_d = ptr_inc;
            PTR_STEP_BOTH: ptr_d = ptr_inc;
            default:       ptr_d = ptr_q;
        endcase
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/fa_nmru_tags.sv
module fa_nmru_tags #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_valid,
    input  logic [TAG_W-1:0]   lkp_tag,
    input  logic               alloc_en,
    input  logic [TAG_W-1:0]   alloc_tag,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [ENTRIES-1:0]            valid;
    logic [ENTRIES-1:0][TAG_W-1:0] tags;
    logic [ENTRIES-1:0]            match;
    logic [IDX_W-1:0]              ptr;
    logic                          ptr_hit;

    fa_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (alloc_en),
        .wr_idx (ptr),
        .wr_tag (alloc_tag),
        .valid  (valid),
        .tags   (tags)
    );

    fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .req   (lkp_valid),
        .key   (lkp_tag),
        .valid (valid),
        .tags  (tags),
        .match (match),
        .any   (hit),
        .first (hit_idx)
    );

    // The pointed entry counts as used whenever it matches, even if a
    // lower-numbered duplicate is the one reported.
    assign ptr_hit = match[ptr];

    fa_nmru_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_hit  (ptr_hit),
        .touch_fill (alloc_en),
        .ptr        (ptr)
    );

    assign victim_idx = ptr;

endmodule

// File: rtl/fa_nmru_tags_chk.sv
module fa_nmru_tags_chk #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_valid,
    input  logic [TAG_W-1:0]   lkp_tag,
    input  logic               alloc_en,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic               hit,
    input  logic [IDX_W-1:0]   hit_idx,
    input  logic [IDX_W-1:0]   victim_idx
);

    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
    endfunction

    a_r1_reset_ptr: assert property (@(posedge clk)
        $rose(rst_n) |-> victim_idx == '0);

    a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> lkp_valid);

    a_r4_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alloc_en) && lkp_valid && lkp_tag == $past(alloc_tag)) |-> hit);

    a_r5_fill_steps: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> victim_idx == nxt($past(victim_idx)));

    a_r6_hit_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && hit_idx == victim_idx) |=> victim_idx == nxt($past(victim_idx)));

    a_r7_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_en && !hit) |=> $stable(victim_idx));

    a_r9_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (victim_idx == $past(victim_idx)) || (victim_idx == nxt($past(victim_idx))));

    a_r10_idx_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> hit_idx == '0);

endmodule

bind fa_nmru_tags fa_nmru_tags_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/fa_nmru_tags_test.sv
module fa_nmru_tags_test;

    localparam int ENTRIES = 16;
    localparam int TAG_W   = 5;
    localparam int IW      = $clog2(ENTRIES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lkp_valid = 1'b0;
    logic [TAG_W-1:0] lkp_tag = '0;
    logic             alloc_en = 1'b0;
    logic [TAG_W-1:0] alloc_tag = '0;
    logic             hit;
    logic [IW-1:0]    hit_idx;
    logic [IW-1:0]    victim_idx;

    always #5 clk = ~clk;

    fa_nmru_tags #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_tag(lkp_tag),
        .alloc_en(alloc_en), .alloc_tag(alloc_tag),
        .hit(hit), .hit_idx(hit_idx), .victim_idx(victim_idx)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic             m_valid [ENTRIES];
    logic [TAG_W-1:0] m_tag   [ENTRIES];
    int               m_ptr;

    function automatic int m_find(input logic [TAG_W-1:0] t);
        for (int i = 0; i < ENTRIES; i++)
            if (m_valid[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit lv, input logic [TAG_W-1:0] lt,
                        input bit av, input logic [TAG_W-1:0] at, input string req);
        int f;
        bit adv;
        @(negedge clk);
        lkp_valid = lv; lkp_tag = lt; alloc_en = av; alloc_tag = at;
        #1;
        f = lv ? m_find(lt) : -1;
        check({req, " hit"}, int'(hit), (f >= 0) ? 1 : 0);
        check({req, " hit_idx"}, int'(hit_idx), (f >= 0) ? f : 0);
        check({req, " victim"}, int'(victim_idx), m_ptr);
        adv = av || (lv && m_valid[m_ptr] && m_tag[m_ptr] == lt);
        if (av) begin
            m_valid[m_ptr] = 1'b1;
            m_tag[m_ptr]   = at;
        end
        if (adv) m_ptr = (m_ptr + 1) % ENTRIES;
    endtask

    initial begin
        #2_000_000ns;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
        end
        m_ptr = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, pointer at 0
        step(1, 5'd0, 0, '0, "R1");
        step(1, 5'd3, 0, '0, "R1");

        // R4 R5: fill every entry in turn
        for (int i = 0; i < ENTRIES; i++) step(0, '0, 1, TAG_W'(i + 1), "R4 R5");

        // R8: pointer wrapped back to 0
        step(0, '0, 0, '0, "R8");
        // R7: hit on an entry other than the pointed one holds the pointer
        step(1, 5'd5, 0, '0, "R7");
        // R6: hit on the pointed entry 0 steps the pointer
        step(1, 5'd1, 0, '0, "R6");
        // R2: request not valid, tag present but ignored; pointer at 1 holds
        step(0, 5'd2, 0, '0, "R2");
        step(0, '0, 0, '0, "R2 R7");
        // R9: lookup of old tag in entry 1 while it is overwritten with a duplicate
        step(1, 5'd2, 1, 5'd5, "R9");
        step(0, '0, 0, '0, "R9");
        // R3: tag 5 now in entries 1 and 4, lowest reported
        step(1, 5'd5, 0, '0, "R3");
        // R10: miss reports index 0
        step(1, 5'd31, 0, '0, "R10");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            bit lv, av;
            logic [TAG_W-1:0] lt, at;
            lv = ($urandom % 10) < 7;
            av = ($urandom % 10) < 3;
            lt = TAG_W'($urandom);
            at = TAG_W'($urandom);
            step(lv, lt, av, at, "R2 R3 R5 R6 R7 R8 R9 R10 rand");
        end

        // Reset again mid-run: R1
        @(negedge clk);
        lkp_valid = 1'b0; alloc_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
        m_ptr = 0;
        step(1, 5'd5, 0, '0, "R1");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule